// File: doc/BRIEF.md
# Post-Corrected Signed Multiply Unit

This is a purely combinational multiply unit. It produces all four integer multiply results from one unsigned multiplier array: the low product word, and the high word for the signed×signed, signed×unsigned and unsigned×unsigned cases. Each operand is treated as unsigned at the array. Its two's-complement weight is then taken out of the high word afterwards.

For each negative operand, the other operand is subtracted from the raw high word. This takes two chained correction stages. Each stage is an adder with a masked second input and a carry-in equal to the controlling sign bit. When the sign bit is clear, the stage passes its word through unchanged. The low word goes from the array straight to the output selector and passes through no correction logic.

The operand width is a parameter. A narrow build can therefore be swept exhaustively, and the default 32-bit build serves the datapath. A 3-bit selector picks the result. Its upper bit is not decoded, so the unit can share the selector lines with a neighbouring divide lane.

Top module: `sfix_mul_unit`

## Requirements
- R1: With selector low bits 00, the result is bits [W-1:0] of the unsigned 2W-bit product of the operands.
- R2: With selector low bits 11, the result is bits [2W-1:W] of the unsigned product of the operands.
- R3: With selector low bits 10, the result is the upper W bits of the 2W-bit product of operand A read as two's complement and operand B read as unsigned.
- R4: With selector low bits 01, the result is the upper W bits of the 2W-bit product of both operands read as two's complement.
- R5: A correction stage whose controlling sign bit is 0 leaves its word unchanged. So the signed×unsigned high word equals the unsigned high word when A is non-negative, and the signed×signed high word equals the signed×unsigned one when B is non-negative. When the sign bit is 1, the stage subtracts its operand modulo 2^W.
- R6: Selector bit 2 has no effect: codes 1xx give the same result as the matching code 0xx.
- R7: At the most negative operand values the corrections wrap modulo 2^W and drop their carry. For W=32, the signed×signed high word of 0x80000000 × 0x80000000 is 0x40000000.
- R8: The width parameter W sets every port and internal width. A 4-bit build gives: low word of 1101×0101 = 0001, signed×unsigned high of 1000×1111 = 1000, signed high of 1101×1011 = 0000, unsigned high of 1111×1111 = 1110.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | W | First operand (multiplicand) |
| op_b | input | W | Second operand (multiplier) |
| op_sel | input | 3 | Result selector; only bits [1:0] are decoded |
| result | output | W | Selected product word |

## Verification
The bench sweeps every operand pair and every selector code of a 4-bit build, so each sign combination, including the most negative value against itself, reaches both correction stages. A stage with an inverted mask, or a carry-in that is missing, would put the high word off by one or by the full operand for exactly the pairs with that sign bit set. A swapped stage operand shows up only when the operands differ, and the exhaustive sweep covers those pairs. A 32-bit build is then driven with random and boundary operands against a 64-bit reference product. This catches a carry dropped across the full width, or a wrong slice for the low word.

// File: rtl/sfix_mul_pkg.sv
package sfix_mul_pkg;
  typedef enum logic [1:0] {
    SEL_LOW  = 2'b00,
    SEL_HSS  = 2'b01,
    SEL_HSU  = 2'b10,
    SEL_HUU  = 2'b11
  } mul_pick_e;
endpackage

// File: rtl/sfix_mul_array.sv
module sfix_mul_array #(
  parameter int W = 32
) (
  input  logic [W-1:0]   mul_x,
  input  logic [W-1:0]   mul_y,
  output logic [2*W-1:0] mul_p
);
  localparam int PW = 2 * W;

  function automatic logic [PW-1:0] umul(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [PW-1:0] xe;
    logic [PW-1:0] ye;
    xe = {{W{1'b0}}, x};
    ye = {{W{1'b0}}, y};
    return xe * ye;
  endfunction

  assign mul_p = umul(mul_x, mul_y);
endmodule

// File: rtl/sfix_fix_stage.sv
module sfix_fix_stage #(
  parameter int W = 32
) (
  input  logic [W-1:0] word_in,
  input  logic [W-1:0] fix_opnd,
  input  logic         fix_sign,
  output logic [W-1:0] word_out
);
  // masked add: word + (mask & (opnd ^ mask)) + sign, carry-out discarded
  function automatic logic [W-1:0] masked_fix(input logic [W-1:0] w,
                                              input logic [W-1:0] o,
                                              input logic         s);
    logic [W-1:0] m;
    logic [W-1:0] t;
    m = {W{s}};
    t = m & (o ^ m);
    return w + t + {{(W-1){1'b0}}, s};
  endfunction

  logic [W-1:0] fixed_w;
  assign fixed_w  = masked_fix(word_in, fix_opnd, fix_sign);
  assign word_out = fixed_w;

  always_comb begin
    if (!fix_sign) begin
      // R5
      pass_thru_chk: assert (word_out == word_in)
        else $error("stage altered word with sign clear");
    end else begin
      // R5
      sub_fix_chk: assert (word_out + fix_opnd == word_in)
        else $error("stage did not subtract operand");
    end
  end
endmodule

// File: rtl/sfix_pick_mux.sv
module sfix_pick_mux
  import sfix_mul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [1:0]   pick,
  input  logic [W-1:0] low_w,
  input  logic [W-1:0] hss_w,
  input  logic [W-1:0] hsu_w,
  input  logic [W-1:0] huu_w,
  output logic [W-1:0] pick_out
);
  mul_pick_e pk;
  assign pk = mul_pick_e'(pick);

  always_comb begin
    unique case (pk)
      SEL_LOW: pick_out = low_w;
      SEL_HSS: pick_out = hss_w;
      SEL_HSU: pick_out = hsu_w;
      SEL_HUU: pick_out = huu_w;
      default: pick_out = low_w;
    endcase
  end
endmodule

// File: rtl/sfix_mul_unit.sv
module sfix_mul_unit
  import sfix_mul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [2:0]   op_sel,
  output logic [W-1:0] result
);
  localparam int PW = 2 * W;

  logic [PW-1:0] raw_prod;
  logic [W-1:0]  raw_lo;
  logic [W-1:0]  raw_hi;
  logic [W-1:0]  fix_a_hi;
  logic [W-1:0]  fix_ab_hi;
  logic          a_neg;
  logic          b_neg;

  assign a_neg = op_a[W-1];
  assign b_neg = op_b[W-1];

  sfix_mul_array #(.W(W)) u_array (
    .mul_x (op_a),
    .mul_y (op_b),
    .mul_p (raw_prod)
  );

  assign raw_lo = raw_prod[W-1:0];
  assign raw_hi = raw_prod[PW-1:W];

  // first stage: removes B * 2^W weight brought in by a negative A
  sfix_fix_stage #(.W(W)) u_fix_a (
    .word_in  (raw_hi),
    .fix_opnd (op_b),
    .fix_sign (a_neg),
    .word_out (fix_a_hi)
  );

  // second stage: removes A * 2^W weight brought in by a negative B
  sfix_fix_stage #(.W(W)) u_fix_b (
    .word_in  (fix_a_hi),
    .fix_opnd (op_a),
    .fix_sign (b_neg),
    .word_out (fix_ab_hi)
  );

  sfix_pick_mux #(.W(W)) u_pick (
    .pick     (op_sel[1:0]),
    .low_w    (raw_lo),
    .hss_w    (fix_ab_hi),
    .hsu_w    (fix_a_hi),
    .huu_w    (raw_hi),
    .pick_out (result)
  );

  always_comb begin
    if (op_sel[1:0] == SEL_LOW) begin
      // R1
      low_word_chk: assert (result == raw_prod[W-1:0])
        else $error("low word not taken from raw product");
    end
    if (op_sel[1:0] == SEL_HUU) begin
      // R2
      high_raw_chk: assert (result == raw_prod[PW-1:W])
        else $error("unsigned high word altered");
    end
    if (op_sel[1:0] == SEL_HSU && !a_neg) begin
      // R3
      hsu_pos_chk: assert (result == raw_prod[PW-1:W])
        else $error("signed-unsigned high differs for non-negative A");
    end
    if (op_sel[1:0] == SEL_HSS && !a_neg && !b_neg) begin
      // R4
      hss_pos_chk: assert (result == raw_prod[PW-1:W])
        else $error("signed high differs for non-negative operands");
    end
  end
endmodule

// File: tb/sfix_mul_unit_bench.sv
module sfix_mul_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam int NL = 32;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [NS-1:0] a_s, b_s, r_s;
  logic [NL-1:0] a_l, b_l, r_l;
  logic [2:0]    sel_s, sel_l;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  sfix_mul_unit #(.W(NS)) u_sfix_mul_unit (
    .op_a(a_s), .op_b(b_s), .op_sel(sel_s), .result(r_s));
  sfix_mul_unit #(.W(NL)) u_sfix_mul_unit_w32 (
    .op_a(a_l), .op_b(b_l), .op_sel(sel_l), .result(r_l));

  // reference: modulo 2^64 product of sign- or zero-extended operands
  function automatic logic [63:0] ref_word(input logic [63:0] a, input logic [63:0] b,
                                           input logic [2:0] s, input int w);
    logic [63:0] msk, ea, eb, ua, ub, p, hi;
    msk = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    ua  = a & msk;
    ub  = b & msk;
    ea  = ua[w-1] ? (ua | ~msk) : ua;
    eb  = ub[w-1] ? (ub | ~msk) : ub;
    case (s[1:0])
      2'b00: p = ua * ub;
      2'b11: p = ua * ub;
      2'b10: p = ea * ub;
      default: p = ea * eb;
    endcase
    hi = (p >> w) & msk;
    return (s[1:0] == 2'b00) ? (p & msk) : hi;
  endfunction

  function automatic string tag_of(input logic [2:0] s);
    if (s[2]) return "R6";
    case (s[1:0])
      2'b00: return "R1";
      2'b01: return "R4";
      2'b10: return "R3";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(input string rq, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h expected %h", rq, got, exp);
    end
  endtask

  task automatic run_s(input logic [NS-1:0] a, input logic [NS-1:0] b, input logic [2:0] s,
                       input string rq, input logic [NS-1:0] exp);
    @(posedge clk);
    a_s = a; b_s = b; sel_s = s;
    @(negedge clk);
    chk(rq, {60'd0, r_s}, {60'd0, exp});
  endtask

  task automatic run_l(input logic [NL-1:0] a, input logic [NL-1:0] b, input logic [2:0] s,
                       input string rq);
    logic [63:0] e;
    @(posedge clk);
    a_l = a; b_l = b; sel_l = s;
    e = ref_word({32'd0, a}, {32'd0, b}, s, NL);
    @(negedge clk);
    chk(rq, {32'd0, r_l}, e);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    a_s = '0; b_s = '0; sel_s = '0;
    a_l = '0; b_l = '0; sel_l = '0;
    @(negedge clk);

    // R8: fixed 4-bit vectors
    run_s(4'b1101, 4'b0101, 3'b000, "R8", 4'b0001);
    run_s(4'b1000, 4'b1111, 3'b010, "R8", 4'b1000);
    run_s(4'b1101, 4'b1011, 3'b001, "R8", 4'b0000);
    run_s(4'b1111, 4'b1111, 3'b011, "R8", 4'b1110);

    // R1 R2 R3 R4 R6: exhaustive 4-bit sweep over all selector codes
    for (int s = 0; s < 8; s++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          run_s(4'(a), 4'(b), 3'(s), tag_of(3'(s)),
                4'(ref_word(64'(a), 64'(b), 3'(s), NS)));

    // R5: non-negative A gives signed-unsigned high == unsigned high;
    // non-negative B gives signed high == signed-unsigned high
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 16; b++)
        run_s(4'(a), 4'(b), 3'b010, "R5", 4'(ref_word(64'(a), 64'(b), 3'b011, NS)));
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 8; b++)
        run_s(4'(a), 4'(b), 3'b001, "R5", 4'(ref_word(64'(a), 64'(b), 3'b010, NS)));

    // R7: extreme values at full width
    run_l(32'h8000_0000, 32'h8000_0000, 3'b001, "R7");
    chk("R7", {32'd0, r_l}, 64'h4000_0000);
    run_l(32'h8000_0000, 32'hFFFF_FFFF, 3'b001, "R7");
    run_l(32'h8000_0000, 32'hFFFF_FFFF, 3'b010, "R7");
    run_l(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b011, "R7");
    run_l(32'h7FFF_FFFF, 32'h8000_0000, 3'b001, "R7");
    run_l(32'h0000_0000, 32'h8000_0000, 3'b001, "R7");

    // R8: random full-width operands against a 64-bit reference
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom;
      rb = $urandom;
      for (int s = 0; s < 4; s++)
        run_l(ra, rb, 3'(s), "R8");
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule